// File: doc/BRIEF.md
# Partition Freeze State Gate

This block keeps an error-isolation flag pair for every partition number and uses it to filter traffic. Each partition has an MMIO freeze flag and a DMA freeze flag. One freeze request raises both flags of a partition together. Software lowers each flag on its own through a clear port.

Three traffic streams pass through the gate, each tagged with a partition number: MMIO loads and stores, DMA reads and writes, and MSI requests. The MMIO flag governs the MMIO stream. The DMA flag governs the DMA and MSI streams.

A request whose partition is not frozen is forwarded one cycle later with its fields unchanged. When the partition is frozen:

- a store is dropped with no trace;
- a load is answered by the gate itself one cycle later, with all-ones data and its tag echoed, so the requester never waits forever;
- an MSI is discarded.

A request is judged against the flag state held before the clock edge that samples it. A reset synchronizer inside the block releases its internal reset two edges after the external reset rises.

Top module: `partition_freeze_gate`

## Requirements
- R1: After reset every partition is unfrozen, so MMIO, DMA and MSI requests to any partition number 0..NPART-1 are forwarded.
- R2: A freeze request for partition P raises both flags of P in the same edge. From the next cycle on, MMIO, DMA and MSI traffic for P is all blocked.
- R3: A clear with the MMIO select set lowers only the MMIO flag of the addressed partition. Its DMA flag stays as it was.
- R4: A clear with the DMA select set lowers only the DMA flag of the addressed partition. Its MMIO flag stays as it was.
- R5: When a freeze and a clear name the same partition in the same cycle, the partition ends up with both flags set.
- R6: A store (store bit = 1) to a frozen partition produces neither a forwarded request nor a completion, on both the MMIO and the DMA path.
- R7: A load (store bit = 0) to a frozen partition produces no forwarded request. One cycle later it produces a completion with valid high, data all ones, and the request's tag.
- R8: An MSI whose partition has its DMA flag set is discarded. An MSI whose partition has only its MMIO flag set is forwarded.
- R9: A request to an unfrozen partition appears on the forward outputs exactly one cycle later, with its store bit, address, data, tag (or MSI partition and vector) unchanged, and produces no completion.
- R10: Flags are kept per partition. A request sampled in the same cycle as a freeze of its partition still sees the old, unfrozen state, and freezing one partition does not affect any other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frz_vld | input | 1 | Freeze request strobe |
| frz_part | input | PW | Partition to freeze |
| clr_vld | input | 1 | Clear request strobe |
| clr_part | input | PW | Partition to clear |
| clr_mmio | input | 1 | Clear selects the MMIO flag |
| clr_dma | input | 1 | Clear selects the DMA flag |
| mm_in_vld | input | 1 | MMIO request valid |
| mm_in_store | input | 1 | MMIO request is a store (1) or a load (0) |
| mm_in_part | input | PW | MMIO request partition |
| mm_in_addr | input | AW | MMIO request address |
| mm_in_wdata | input | DW | MMIO store data |
| mm_in_tag | input | TW | MMIO request tag |
| mm_fwd_vld | output | 1 | Forwarded MMIO request valid |
| mm_fwd_store | output | 1 | Forwarded MMIO store bit |
| mm_fwd_addr | output | AW | Forwarded MMIO address |
| mm_fwd_wdata | output | DW | Forwarded MMIO store data |
| mm_fwd_tag | output | TW | Forwarded MMIO tag |
| mm_cpl_vld | output | 1 | Gate-generated MMIO load completion valid |
| mm_cpl_data | output | DW | Completion data (all ones) |
| mm_cpl_tag | output | TW | Completion tag |
| dma_in_vld | input | 1 | DMA request valid |
| dma_in_store | input | 1 | DMA request is a write (1) or a read (0) |
| dma_in_part | input | PW | DMA request partition |
| dma_in_addr | input | AW | DMA request address |
| dma_in_wdata | input | DW | DMA write data |
| dma_in_tag | input | TW | DMA request tag |
| dma_fwd_vld | output | 1 | Forwarded DMA request valid |
| dma_fwd_store | output | 1 | Forwarded DMA write bit |
| dma_fwd_addr | output | AW | Forwarded DMA address |
| dma_fwd_wdata | output | DW | Forwarded DMA data |
| dma_fwd_tag | output | TW | Forwarded DMA tag |
| dma_cpl_vld | output | 1 | Gate-generated DMA read completion valid |
| dma_cpl_data | output | DW | Completion data (all ones) |
| dma_cpl_tag | output | TW | Completion tag |
| msi_in_vld | input | 1 | MSI request valid |
| msi_in_part | input | PW | MSI source partition |
| msi_in_vec | input | VW | MSI vector |
| msi_out_vld | output | 1 | Forwarded MSI valid |
| msi_out_part | output | PW | Forwarded MSI partition |
| msi_out_vec | output | VW | Forwarded MSI vector |

## Verification
The bench builds the gate with its defaults: 256 partitions, 32-bit addresses, 64-bit data, 6-bit tags and 11-bit MSI vectors. With the full partition range it can sweep every partition number once with all three streams. That sweep reaches the top entry, 255, where an undersized index would wrap. The wide data path makes any all-ones completion with a cleared bit visible. A long stretch of random traffic, confined to a handful of partitions, then mixes freezes, one-sided clears and same-cycle freeze/clear collisions with loads and stores, so every flag combination meets every request kind.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  // Access kind carried by the store bit of MMIO and DMA requests
  typedef enum logic {
    ACC_LOAD  = 1'b0,
    ACC_STORE = 1'b1
  } acc_e;

  // Read-port assignment of the flag table
  localparam int RP_MM  = 0;
  localparam int RP_DMA = 1;
  localparam int RP_MSI = 2;
  localparam int RP_NUM = 3;
endpackage

// File: rtl/pfg_rst_sync.sv
module pfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/pfg_table.sv
module pfg_table #(
  parameter int NPART = 256,
  parameter int NRD   = 3,
  localparam int PW   = (NPART > 1) ? $clog2(NPART) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frz_vld,
  input  logic [PW-1:0]            frz_part,
  input  logic                     clr_vld,
  input  logic [PW-1:0]            clr_part,
  input  logic                     clr_mmio,
  input  logic                     clr_dma,
  input  logic [NRD-1:0][PW-1:0]   rd_part,
  output logic [NRD-1:0]           rd_mm,
  output logic [NRD-1:0]           rd_dma
);
  logic [NPART-1:0] mm_q, mm_d, dma_q, dma_d, ent_en;

  // Next state per entry: a freeze overrides a clear aimed at the same entry
  for (genvar i = 0; i < NPART; i++) begin : g_ent
    logic hit_f, hit_c;
    always_comb begin
      hit_f     = frz_vld && (frz_part == PW'(i));
      hit_c     = clr_vld && (clr_part == PW'(i));
      ent_en[i] = hit_f || hit_c;
      mm_d[i]   = hit_f || (mm_q[i]  && !clr_mmio);
      dma_d[i]  = hit_f || (dma_q[i] && !clr_dma);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mm_q[i]  <= 1'b0;
        dma_q[i] <= 1'b0;
      end else if (ent_en[i]) begin
        mm_q[i]  <= mm_d[i];
        dma_q[i] <= dma_d[i];
      end
    end
  end

  // Lookup ports: a partition number outside the table reads as unfrozen
  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic in_rng;
    always_comb begin
      in_rng    = ({1'b0, rd_part[r]} < (PW+1)'(NPART));
      rd_mm[r]  = in_rng && mm_q[rd_part[r]];
      rd_dma[r] = in_rng && dma_q[rd_part[r]];
    end
  end
endmodule

// File: rtl/pfg_path.sv
module pfg_path
  import pfg_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_store,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic [TW-1:0] in_tag,
  input  logic          frozen,
  output logic          fwd_vld,
  output logic          fwd_store,
  output logic [AW-1:0] fwd_addr,
  output logic [DW-1:0] fwd_wdata,
  output logic [TW-1:0] fwd_tag,
  output logic          cpl_vld,
  output logic [DW-1:0] cpl_data,
  output logic [TW-1:0] cpl_tag
);
  acc_e          kind;
  logic          pass_d, blk_ld_d;
  logic          fwd_vld_q, fwd_store_q, cpl_vld_q;
  logic [AW-1:0] fwd_addr_q;
  logic [DW-1:0] fwd_wdata_q, cpl_data_q;
  logic [TW-1:0] fwd_tag_q, cpl_tag_q;

  always_comb begin
    kind     = acc_e'(in_store);
    pass_d   = in_vld && !frozen;
    blk_ld_d = in_vld && frozen && (kind == ACC_LOAD);
  end

  // Valid flags: reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_vld_q <= 1'b0;
      cpl_vld_q <= 1'b0;
    end else begin
      fwd_vld_q <= pass_d;
      cpl_vld_q <= blk_ld_d;
    end
  end

  // Payloads: loaded only when their valid is raised
  always_ff @(posedge clk) begin
    if (pass_d) begin
      fwd_store_q <= in_store;
      fwd_addr_q  <= in_addr;
      fwd_wdata_q <= in_wdata;
      fwd_tag_q   <= in_tag;
    end
    if (blk_ld_d) begin
      cpl_data_q <= {DW{1'b1}};
      cpl_tag_q  <= in_tag;
    end
  end

  assign fwd_vld   = fwd_vld_q;
  assign fwd_store = fwd_store_q;
  assign fwd_addr  = fwd_addr_q;
  assign fwd_wdata = fwd_wdata_q;
  assign fwd_tag   = fwd_tag_q;
  assign cpl_vld   = cpl_vld_q;
  assign cpl_data  = cpl_data_q;
  assign cpl_tag   = cpl_tag_q;
endmodule

// File: rtl/pfg_msi.sv
module pfg_msi #(
  parameter int PW = 8,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [PW-1:0] in_part,
  input  logic [VW-1:0] in_vec,
  input  logic          frozen,
  output logic          out_vld,
  output logic [PW-1:0] out_part,
  output logic [VW-1:0] out_vec
);
  logic          pass_d, vld_q;
  logic [PW-1:0] part_q;
  logic [VW-1:0] vec_q;

  always_comb pass_d = in_vld && !frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= pass_d;
  end

  always_ff @(posedge clk) begin
    if (pass_d) begin
      part_q <= in_part;
      vec_q  <= in_vec;
    end
  end

  assign out_vld  = vld_q;
  assign out_part = part_q;
  assign out_vec  = vec_q;
endmodule

// File: rtl/partition_freeze_gate.sv
module partition_freeze_gate
  import pfg_pkg::*;
#(
  parameter int NPART = 256,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int TW    = 6,
  parameter int VW    = 11,
  localparam int PW   = (NPART > 1) ? $clog2(NPART) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frz_vld,
  input  logic [PW-1:0] frz_part,
  input  logic          clr_vld,
  input  logic [PW-1:0] clr_part,
  input  logic          clr_mmio,
  input  logic          clr_dma,
  input  logic          mm_in_vld,
  input  logic          mm_in_store,
  input  logic [PW-1:0] mm_in_part,
  input  logic [AW-1:0] mm_in_addr,
  input  logic [DW-1:0] mm_in_wdata,
  input  logic [TW-1:0] mm_in_tag,
  output logic          mm_fwd_vld,
  output logic          mm_fwd_store,
  output logic [AW-1:0] mm_fwd_addr,
  output logic [DW-1:0] mm_fwd_wdata,
  output logic [TW-1:0] mm_fwd_tag,
  output logic          mm_cpl_vld,
  output logic [DW-1:0] mm_cpl_data,
  output logic [TW-1:0] mm_cpl_tag,
  input  logic          dma_in_vld,
  input  logic          dma_in_store,
  input  logic [PW-1:0] dma_in_part,
  input  logic [AW-1:0] dma_in_addr,
  input  logic [DW-1:0] dma_in_wdata,
  input  logic [TW-1:0] dma_in_tag,
  output logic          dma_fwd_vld,
  output logic          dma_fwd_store,
  output logic [AW-1:0] dma_fwd_addr,
  output logic [DW-1:0] dma_fwd_wdata,
  output logic [TW-1:0] dma_fwd_tag,
  output logic          dma_cpl_vld,
  output logic [DW-1:0] dma_cpl_data,
  output logic [TW-1:0] dma_cpl_tag,
  input  logic          msi_in_vld,
  input  logic [PW-1:0] msi_in_part,
  input  logic [VW-1:0] msi_in_vec,
  output logic          msi_out_vld,
  output logic [PW-1:0] msi_out_part,
  output logic [VW-1:0] msi_out_vec
);
  logic                      rst_n_sync;
  logic [RP_NUM-1:0][PW-1:0] rd_part;
  logic [RP_NUM-1:0]         rd_mm, rd_dma;
  logic                      mm_frz, dma_frz, msi_frz;

  pfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    rd_part[RP_MM]  = mm_in_part;
    rd_part[RP_DMA] = dma_in_part;
    rd_part[RP_MSI] = msi_in_part;
    // MMIO flag guards MMIO; DMA flag guards DMA and MSI
    mm_frz  = rd_mm[RP_MM];
    dma_frz = rd_dma[RP_DMA];
    msi_frz = rd_dma[RP_MSI];
  end

  pfg_table #(.NPART(NPART), .NRD(RP_NUM)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .frz_vld  (frz_vld),
    .frz_part (frz_part),
    .clr_vld  (clr_vld),
    .clr_part (clr_part),
    .clr_mmio (clr_mmio),
    .clr_dma  (clr_dma),
    .rd_part  (rd_part),
    .rd_mm    (rd_mm),
    .rd_dma   (rd_dma)
  );

  pfg_path #(.AW(AW), .DW(DW), .TW(TW)) u_mm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_vld    (mm_in_vld),
    .in_store  (mm_in_store),
    .in_addr   (mm_in_addr),
    .in_wdata  (mm_in_wdata),
    .in_tag    (mm_in_tag),
    .frozen    (mm_frz),
    .fwd_vld   (mm_fwd_vld),
    .fwd_store (mm_fwd_store),
    .fwd_addr  (mm_fwd_addr),
    .fwd_wdata (mm_fwd_wdata),
    .fwd_tag   (mm_fwd_tag),
    .cpl_vld   (mm_cpl_vld),
    .cpl_data  (mm_cpl_data),
    .cpl_tag   (mm_cpl_tag)
  );

  pfg_path #(.AW(AW), .DW(DW), .TW(TW)) u_dma (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .in_vld    (dma_in_vld),
    .in_store  (dma_in_store),
    .in_addr   (dma_in_addr),
    .in_wdata  (dma_in_wdata),
    .in_tag    (dma_in_tag),
    .frozen    (dma_frz),
    .fwd_vld   (dma_fwd_vld),
    .fwd_store (dma_fwd_store),
    .fwd_addr  (dma_fwd_addr),
    .fwd_wdata (dma_fwd_wdata),
    .fwd_tag   (dma_fwd_tag),
    .cpl_vld   (dma_cpl_vld),
    .cpl_data  (dma_cpl_data),
    .cpl_tag   (dma_cpl_tag)
  );

  pfg_msi #(.PW(PW), .VW(VW)) u_msi (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .in_vld   (msi_in_vld),
    .in_part  (msi_in_part),
    .in_vec   (msi_in_vec),
    .frozen   (msi_frz),
    .out_vld  (msi_out_vld),
    .out_part (msi_out_part),
    .out_vec  (msi_out_vec)
  );
endmodule

// File: rtl/pfg_chk.sv
module pfg_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mm_in_vld,
  input logic          mm_in_store,
  input logic          mm_frz,
  input logic          mm_fwd_vld,
  input logic          mm_cpl_vld,
  input logic [DW-1:0] mm_cpl_data,
  input logic          dma_in_vld,
  input logic          dma_in_store,
  input logic          dma_frz,
  input logic          dma_fwd_vld,
  input logic          dma_cpl_vld,
  input logic [DW-1:0] dma_cpl_data,
  input logic          msi_in_vld,
  input logic          msi_frz,
  input logic          msi_out_vld
);
  // Becomes 1 one edge after reset release, so $past never reaches into reset
  logic armed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_mm_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_fwd_vld && mm_cpl_vld));
  assert_dma_one_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_fwd_vld && dma_cpl_vld));

  assert_mm_cpl_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mm_cpl_vld |-> (mm_cpl_data == {DW{1'b1}}));
  assert_dma_cpl_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_cpl_vld |-> (dma_cpl_data == {DW{1'b1}}));

  assert_mm_blocked_load_cpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(mm_in_vld && mm_frz && !mm_in_store)) |-> (mm_cpl_vld && !mm_fwd_vld));

  assert_mm_store_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(mm_in_vld && mm_frz && mm_in_store)) |-> (!mm_cpl_vld && !mm_fwd_vld));
  assert_dma_store_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(dma_in_vld && dma_frz && dma_in_store)) |-> (!dma_cpl_vld && !dma_fwd_vld));

  assert_mm_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(mm_in_vld && !mm_frz)) |-> (mm_fwd_vld && !mm_cpl_vld));
  assert_dma_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(dma_in_vld && !dma_frz)) |-> (dma_fwd_vld && !dma_cpl_vld));

  assert_msi_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(msi_in_vld && msi_frz)) |-> !msi_out_vld);
  assert_msi_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(msi_in_vld && !msi_frz)) |-> msi_out_vld);
endmodule

bind partition_freeze_gate pfg_chk #(.DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .mm_in_vld    (mm_in_vld),
  .mm_in_store  (mm_in_store),
  .mm_frz       (mm_frz),
  .mm_fwd_vld   (mm_fwd_vld),
  .mm_cpl_vld   (mm_cpl_vld),
  .mm_cpl_data  (mm_cpl_data),
  .dma_in_vld   (dma_in_vld),
  .dma_in_store (dma_in_store),
  .dma_frz      (dma_frz),
  .dma_fwd_vld  (dma_fwd_vld),
  .dma_cpl_vld  (dma_cpl_vld),
  .dma_cpl_data (dma_cpl_data),
  .msi_in_vld   (msi_in_vld),
  .msi_frz      (msi_frz),
  .msi_out_vld  (msi_out_vld)
);

// File: tb/sim_partition_freeze_gate.sv
module sim_partition_freeze_gate;
  localparam int NPART = 256;
  localparam int AW = 32, DW = 64, TW = 6, VW = 11, PW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic frz_vld, clr_vld, clr_mmio, clr_dma;
  logic [PW-1:0] frz_part, clr_part;
  logic mm_in_vld, mm_in_store, dma_in_vld, dma_in_store, msi_in_vld;
  logic [PW-1:0] mm_in_part, dma_in_part, msi_in_part;
  logic [AW-1:0] mm_in_addr, dma_in_addr;
  logic [DW-1:0] mm_in_wdata, dma_in_wdata;
  logic [TW-1:0] mm_in_tag, dma_in_tag;
  logic [VW-1:0] msi_in_vec;
  logic mm_fwd_vld, mm_fwd_store, mm_cpl_vld, dma_fwd_vld, dma_fwd_store, dma_cpl_vld;
  logic [AW-1:0] mm_fwd_addr, dma_fwd_addr;
  logic [DW-1:0] mm_fwd_wdata, mm_cpl_data, dma_fwd_wdata, dma_cpl_data;
  logic [TW-1:0] mm_fwd_tag, mm_cpl_tag, dma_fwd_tag, dma_cpl_tag;
  logic msi_out_vld;
  logic [PW-1:0] msi_out_part;
  logic [VW-1:0] msi_out_vec;

  partition_freeze_gate #(.NPART(NPART), .AW(AW), .DW(DW), .TW(TW), .VW(VW)) u0 (.*);

  // Reference model state
  bit mmf [NPART];
  bit dmf [NPART];
  int errors = 0, checks = 0;
  string ph = "R1";
  bit done = 1'b0;

  // Expected outputs for the coming edge
  bit e_mm_fwd, e_mm_cpl, e_dma_fwd, e_dma_cpl, e_msi;
  logic [AW+DW+TW:0] e_mm_pl, e_dma_pl;
  logic [TW-1:0] e_mm_tag, e_dma_tag;
  logic [PW+VW-1:0] e_msi_pl;

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", ph, what, act, exp);
    end
  endtask

  task automatic idle();
    frz_vld = 0; clr_vld = 0; clr_mmio = 0; clr_dma = 0;
    frz_part = '0; clr_part = '0;
    mm_in_vld = 0; mm_in_store = 0; mm_in_part = '0; mm_in_addr = '0; mm_in_wdata = '0; mm_in_tag = '0;
    dma_in_vld = 0; dma_in_store = 0; dma_in_part = '0; dma_in_addr = '0; dma_in_wdata = '0; dma_in_tag = '0;
    msi_in_vld = 0; msi_in_part = '0; msi_in_vec = '0;
  endtask

  // Predict from pre-edge model state, update model, cross the edge, compare
  task automatic tick();
    e_mm_fwd  = mm_in_vld && !mmf[mm_in_part];
    e_mm_cpl  = mm_in_vld && mmf[mm_in_part] && !mm_in_store;
    e_mm_pl   = {mm_in_store, mm_in_addr, mm_in_wdata, mm_in_tag};
    e_mm_tag  = mm_in_tag;
    e_dma_fwd = dma_in_vld && !dmf[dma_in_part];
    e_dma_cpl = dma_in_vld && dmf[dma_in_part] && !dma_in_store;
    e_dma_pl  = {dma_in_store, dma_in_addr, dma_in_wdata, dma_in_tag};
    e_dma_tag = dma_in_tag;
    e_msi     = msi_in_vld && !dmf[msi_in_part];
    e_msi_pl  = {msi_in_part, msi_in_vec};
    if (clr_vld) begin
      if (clr_mmio) mmf[clr_part] = 1'b0;
      if (clr_dma)  dmf[clr_part] = 1'b0;
    end
    if (frz_vld) begin
      mmf[frz_part] = 1'b1;
      dmf[frz_part] = 1'b1;
    end
    @(negedge clk);
    chk("mm_fwd_vld", 128'(mm_fwd_vld), 128'(e_mm_fwd));
    if (e_mm_fwd) chk("mm_fwd_payload", 128'({mm_fwd_store, mm_fwd_addr, mm_fwd_wdata, mm_fwd_tag}), 128'(e_mm_pl));
    chk("mm_cpl_vld", 128'(mm_cpl_vld), 128'(e_mm_cpl));
    if (e_mm_cpl) chk("mm_cpl_data_tag", 128'({mm_cpl_data, mm_cpl_tag}), 128'({{DW{1'b1}}, e_mm_tag}));
    chk("dma_fwd_vld", 128'(dma_fwd_vld), 128'(e_dma_fwd));
    if (e_dma_fwd) chk("dma_fwd_payload", 128'({dma_fwd_store, dma_fwd_addr, dma_fwd_wdata, dma_fwd_tag}), 128'(e_dma_pl));
    chk("dma_cpl_vld", 128'(dma_cpl_vld), 128'(e_dma_cpl));
    if (e_dma_cpl) chk("dma_cpl_data_tag", 128'({dma_cpl_data, dma_cpl_tag}), 128'({{DW{1'b1}}, e_dma_tag}));
    chk("msi_out_vld", 128'(msi_out_vld), 128'(e_msi));
    if (e_msi) chk("msi_payload", 128'({msi_out_part, msi_out_vec}), 128'(e_msi_pl));
    idle();
  endtask

  task automatic req_all(input logic [PW-1:0] p, input bit st);
    mm_in_vld = 1; mm_in_store = st; mm_in_part = p; mm_in_addr = $urandom; mm_in_wdata = {$urandom, $urandom}; mm_in_tag = TW'($urandom);
    dma_in_vld = 1; dma_in_store = st; dma_in_part = p; dma_in_addr = $urandom; dma_in_wdata = {$urandom, $urandom}; dma_in_tag = TW'($urandom);
    msi_in_vld = 1; msi_in_part = p; msi_in_vec = VW'($urandom);
  endtask

  function automatic logic [PW-1:0] pick();
    logic [PW-1:0] set [5] = '{8'd0, 8'd1, 8'd2, 8'd128, 8'd255};
    return set[$urandom_range(0, 4)];
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NPART; i++) begin mmf[i] = 0; dmf[i] = 0; end
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle through reset synchronizer, then every partition forwards
    ph = "R1";
    repeat (4) tick();
    for (int p = 0; p < NPART; p++) begin req_all(PW'(p), p[0]); tick(); end

    // R2: freeze sets both flags; loads answered with ones (R7), stores dropped (R6), MSI blocked (R8)
    ph = "R2"; frz_vld = 1; frz_part = 8'd5; tick();
    req_all(8'd5, 0); tick();
    ph = "R6"; req_all(8'd5, 1); tick();
    ph = "R7"; req_all(8'd5, 0); tick();

    // R3: clear MMIO flag only
    ph = "R3"; clr_vld = 1; clr_part = 8'd5; clr_mmio = 1; tick();
    req_all(8'd5, 0); tick();
    req_all(8'd5, 1); tick();

    // R4: clear DMA flag only; MSI passes with only MMIO frozen (R8)
    ph = "R4"; frz_vld = 1; frz_part = 8'd7; tick();
    clr_vld = 1; clr_part = 8'd7; clr_dma = 1; tick();
    req_all(8'd7, 0); tick();
    ph = "R8"; req_all(8'd7, 1); tick();

    // R5: freeze and clear on same partition in same cycle
    ph = "R5"; frz_vld = 1; frz_part = 8'd9; clr_vld = 1; clr_part = 8'd9; clr_mmio = 1; clr_dma = 1; tick();
    req_all(8'd9, 0); tick();

    // R10: request in the freeze cycle sees old state; neighbour unaffected
    ph = "R10"; frz_vld = 1; frz_part = 8'd255; req_all(8'd255, 0); tick();
    req_all(8'd255, 0); tick();
    req_all(8'd254, 0); tick();
    clr_vld = 1; clr_part = 8'd255; clr_mmio = 1; clr_dma = 1; tick();

    // R9: random mix of traffic, freezes and clears
    ph = "R9";
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 9) == 0) begin frz_vld = 1; frz_part = pick(); end
      if ($urandom_range(0, 5) == 0) begin
        clr_vld = 1; clr_part = pick(); clr_mmio = 1'($urandom); clr_dma = 1'($urandom);
      end
      if ($urandom_range(0, 1) == 1) begin
        mm_in_vld = 1; mm_in_store = 1'($urandom); mm_in_part = pick();
        mm_in_addr = $urandom; mm_in_wdata = {$urandom, $urandom}; mm_in_tag = TW'($urandom);
      end
      if ($urandom_range(0, 1) == 1) begin
        dma_in_vld = 1; dma_in_store = 1'($urandom); dma_in_part = pick();
        dma_in_addr = $urandom; dma_in_wdata = {$urandom, $urandom}; dma_in_tag = TW'($urandom);
      end
      if ($urandom_range(0, 2) == 0) begin
        msi_in_vld = 1; msi_in_part = pick(); msi_in_vec = VW'($urandom);
      end
      tick();
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule